// File: doc/BRIEF.md
# Asynchronous Serial Port with Status Flags

This block is a full-duplex asynchronous serial port that a host drives through four word-wide registers. The host enables each direction, chooses an 8-bit or 9-bit character, and sets a clock divider that fixes the bit time. A write to the data register queues a character for the transmitter. The receiver oversamples the incoming line and places each character in a read buffer. A set of sticky flags reports what happened, and one level interrupt line combines the flags with their enables.

Every character uses NRZ framing and is sent least significant bit first. A low start bit comes first, then the data bits, then a high stop bit. The transmitter can also send all-low break frames. The receiver can also sleep until the line has been idle for a full character time. The flags follow strict rules. Transmit-complete stays low while anything is still pending. Turning the transmitter off never cuts a character short. The idle flag needs a good character before it can be set.

Top module: `async_serial_port`

Register map (`bus_addr`):
- 0 = data. A write queues a transmit character. A read returns the receive buffer.
- 1 = status: [0] transmit buffer empty, [1] transmit complete, [2] receive full, [3] line idle, [4] overrun, [5] noise, [6] framing error.
- 2 = control: [0] transmit enable, [1] receive enable, [2] interrupt on transmit empty, [3] interrupt on transmit complete, [4] interrupt on receive full or overrun, [5] interrupt on idle, [6] receiver sleep, [7] send break, [8] 9-bit characters.
- 3 = divider D.

## Requirements
- R1: After reset the status reads 0x0003 (transmit empty and transmit complete set, all others clear), `txd` is high and `irq` is low.
- R2: A frame is one low start bit, then 8 data bits (or 9 when control bit 8 is set) sent LSB first, then one high stop bit. Each bit lasts 16*(D+1) clock cycles.
- R3: A data write clears status bit 0. Bit 0 sets again when the character moves into the shifter, and that move happens only at a bit boundary.
- R4: Status bit 1 is low while a character is being shifted or while data, a preamble or a break is pending with the transmitter enabled. It sets once the stop bit has finished and nothing is pending, and also when the transmitter is disabled with its shifter empty. Turning the transmitter on queues one all-high preamble frame ahead of any data.
- R5: Clearing transmit enable in the middle of a character lets that character finish in full. After that, `txd` stays high.
- R6: While send break (control bit 7) is set, the transmitter sends whole frames with `txd` low throughout. After the bit clears, the frame in progress ends and the line returns high.
- R7: A received character with the receiver enabled is copied to the read buffer and sets status bit 2.
- R8: When a character completes while bit 2 is still set, the overrun flag (bit 4) sets, the new character is dropped, and the buffer keeps the older one.
- R9: Each bit is sampled three times around its middle and the majority value is taken. If the three samples in any bit disagree, status bit 5 is set along with that character.
- R10: A stop bit whose majority value is low sets status bit 6.
- R11: Status bit 3 sets after one full character time of high line, and only if a character without a framing error has arrived since the last idle event.
- R12: Reading status and then reading data clears bits 2 through 6. Reading status alone clears nothing.
- R13: `irq` is high when any enabled flag is set (transmit empty, transmit complete, receive full or overrun, idle), and low otherwise.
- R14: While receiver sleep (control bit 6) is set, received characters are ignored. One full character time of idle line clears the sleep bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after a read |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, high when idle |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench writes a second character while the first is still on the line. It checks that the empty flag stays low until the start of the second frame and that the complete flag waits for the end. A design that loads early, or reports completion after the first frame, fails there. It drops transmit enable three bits into a character and expects the full frame. It also checks that one break frame is sent and that the line goes high afterwards; a truncating design would leave a short or stuck frame. On the receive side, a single-sample glitch must raise the noise flag without corrupting data. A second character must not overwrite an unread one. A framing-error character, or an idle period with no new character, must not raise the idle flag. Receiver sleep must swallow one character and then wake on an idle line.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  localparam int OVS = 16;
  localparam int SUBW = $clog2(OVS);
  localparam int FRW = 11;
  typedef enum logic [0:0] {RX_IDLE, RX_BITS} rx_state_e;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;
endpackage

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] div,
  output logic            tick16,
  output logic            bit_tick
);
  import serial_port_pkg::*;
  logic [DIVW-1:0] cnt;
  logic [SUBW-1:0] sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sub <= '0;
      tick16 <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      tick16 <= 1'b0;
      bit_tick <= 1'b0;
      if (cnt >= div) begin
        cnt <= '0;
        tick16 <= 1'b1;
        sub <= sub + 1'b1;
        if (sub == SUBW'(OVS - 1)) bit_tick <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: a bit boundary always coincides with an oversample tick
  a_r2_bit_on_tick: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> tick16);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_tick,
  input  logic       te,
  input  logic       nine,
  input  logic       have_pre,
  input  logic       have_data,
  input  logic       brk,
  input  logic [8:0] data,
  output logic       txd,
  output logic       take,
  output logic       pre_take,
  output logic       line_busy
);
  import serial_port_pkg::*;
  logic [FRW-1:0] sr;
  logic [FRW-1:0] frame;
  logic [3:0]     left;
  logic [3:0]     nbits;
  logic           brk_frame;
  logic           start_new;

  assign nbits = nine ? 4'd11 : 4'd10;
  assign start_new = te && (have_pre || have_data || brk);

  always_comb begin
    if (have_pre)       frame = '1;
    else if (have_data) frame = nine ? {1'b1, data, 1'b0} : {2'b11, data[7:0], 1'b0};
    else                frame = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '1;
      left <= '0;
      txd <= 1'b1;
      take <= 1'b0;
      pre_take <= 1'b0;
      line_busy <= 1'b0;
      brk_frame <= 1'b0;
    end else begin
      take <= 1'b0;
      pre_take <= 1'b0;
      if (bit_tick) begin
        if (left != 4'd0) begin
          txd <= sr[0];
          sr <= {1'b1, sr[FRW-1:1]};
          left <= left - 4'd1;
        end else if (start_new) begin
          txd <= frame[0];
          sr <= {1'b1, frame[FRW-1:1]};
          left <= nbits - 4'd1;
          line_busy <= 1'b1;
          pre_take <= have_pre;
          take <= !have_pre && have_data;
          brk_frame <= !have_pre && !have_data;
        end else begin
          txd <= 1'b1;
          line_busy <= 1'b0;
          brk_frame <= 1'b0;
        end
      end
    end
  end

  // R5: a started character counts down whatever the enable does
  a_r5_char_runs: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && left != 4'd0) |=> (left == $past(left) - 4'd1));
  // R6: a break frame keeps the line low
  a_r6_break_low: assert property (@(posedge clk) disable iff (rst)
    (brk_frame && line_busy) |-> !txd);
endmodule

// File: rtl/rx_sampler.sv
module rx_sampler (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       nine,
  output logic       done,
  output logic [8:0] rdata,
  output logic       noise,
  output logic       ferr,
  output logic       idle_line
);
  import serial_port_pkg::*;
  localparam int ICW = $clog2(FRW * OVS + 1);
  localparam logic [SUBW-1:0] S_A = SUBW'(OVS / 2 - 1);
  localparam logic [SUBW-1:0] S_B = SUBW'(OVS / 2);
  localparam logic [SUBW-1:0] S_C = SUBW'(OVS / 2 + 1);
  localparam logic [SUBW-1:0] S_L = SUBW'(OVS - 1);

  rx_state_e       st;
  logic            s1, s2;
  logic [SUBW-1:0] sub;
  logic [3:0]      bidx;
  logic [1:0]      smp;
  logic [8:0]      sh;
  logic            nacc;
  logic [ICW-1:0]  icnt;
  logic [ICW-1:0]  thr;
  logic [3:0]      last;
  logic            maj, dis;

  assign thr  = nine ? ICW'(11 * OVS) : ICW'(10 * OVS);
  assign last = nine ? 4'd10 : 4'd9;
  assign maj  = (smp[0] & smp[1]) | (smp[0] & s2) | (smp[1] & s2);
  assign dis  = !((smp[0] == smp[1]) && (smp[1] == s2));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      st <= RX_IDLE;
      sub <= '0;
      bidx <= '0;
      smp <= '0;
      sh <= '0;
      nacc <= 1'b0;
      icnt <= '0;
      done <= 1'b0;
      rdata <= '0;
      noise <= 1'b0;
      ferr <= 1'b0;
      idle_line <= 1'b0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      done <= 1'b0;
      idle_line <= 1'b0;
      if (tick16) begin
        case (st)
          RX_IDLE: begin
            if (!s2) begin
              st <= RX_BITS;
              sub <= SUBW'(1);
              bidx <= '0;
              nacc <= 1'b0;
              icnt <= '0;
            end else if (icnt < thr) begin
              icnt <= icnt + 1'b1;
              if (icnt == thr - 1'b1) idle_line <= 1'b1;
            end
          end
          default: begin
            sub <= sub + 1'b1;
            if (sub == S_A) smp[0] <= s2;
            if (sub == S_B) smp[1] <= s2;
            if (sub == S_C) begin
              if (bidx == 4'd0) begin
                if (maj) st <= RX_IDLE;
                else nacc <= nacc | dis;
              end else if (bidx == last) begin
                done <= 1'b1;
                ferr <= !maj;
                noise <= nacc | dis;
                rdata <= nine ? sh : {1'b0, sh[8:1]};
                st <= RX_IDLE;
              end else begin
                sh <= {maj, sh[8:1]};
                nacc <= nacc | dis;
              end
            end
            if (sub == S_L) bidx <= bidx + 4'd1;
          end
        endcase
      end
    end
  end

  // R11: the idle event fires only from the waiting state on a high line
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    idle_line |-> (st == RX_IDLE));
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port #(
  parameter int DW = 16,
  parameter int DIVW = 16,
  parameter int DIV_RESET = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rxd,
  output logic          txd,
  output logic          irq
);
  import serial_port_pkg::*;

  logic te, re, tie, tcie, rie, ilie, rwu, sbk, nine;
  logic [DIVW-1:0] div;
  logic [8:0] tx_buf, rx_buf;
  logic pend, pre, tc_r;
  logic rdrf, ovr, nf, fe, idle_f, seen_char, st_armed;
  logic tick16, bit_tick;
  logic tx_take, tx_pre_take, tx_busy;
  logic rx_done, rx_noise, rx_ferr, rx_idle;
  logic [8:0] rx_data;
  logic wr, rd, data_wr, ctrl_wr, clr, acc;
  logic [DW-1:0] stat_w, ctrl_w, rd_mux;

  assign wr = bus_en && bus_we;
  assign rd = bus_en && !bus_we;
  assign data_wr = wr && bus_addr == A_DATA;
  assign ctrl_wr = wr && bus_addr == A_CTRL;
  assign clr = rd && bus_addr == A_DATA && st_armed;
  assign acc = rx_done && re && !rwu;

  baud_divider #(.DIVW(DIVW)) u_baud (
    .clk(clk), .rst(rst), .div(div), .tick16(tick16), .bit_tick(bit_tick));

  tx_shifter u_tx (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .te(te), .nine(nine),
    .have_pre(pre), .have_data(pend), .brk(sbk), .data(tx_buf),
    .txd(txd), .take(tx_take), .pre_take(tx_pre_take), .line_busy(tx_busy));

  rx_sampler u_rx (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .nine(nine),
    .done(rx_done), .rdata(rx_data), .noise(rx_noise), .ferr(rx_ferr),
    .idle_line(rx_idle));

  // control and divider registers
  always_ff @(posedge clk) begin
    if (rst) begin
      {te, re, tie, tcie, rie, ilie, rwu, sbk, nine} <= '0;
      div <= DIVW'(DIV_RESET);
      pre <= 1'b0;
    end else begin
      if (rx_idle && rwu) rwu <= 1'b0;
      if (tx_pre_take || !te) pre <= 1'b0;
      if (ctrl_wr) begin
        {nine, sbk, rwu, ilie, rie, tcie, tie, re, te} <= bus_wdata[8:0];
        if (bus_wdata[0] && !te) pre <= 1'b1;
      end
      if (wr && bus_addr == A_DIV) div <= bus_wdata[DIVW-1:0];
    end
  end

  // transmit buffer and completion
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf <= '0;
      pend <= 1'b0;
      tc_r <= 1'b1;
    end else begin
      if (tx_take) pend <= 1'b0;
      if (data_wr) begin
        tx_buf <= bus_wdata[8:0];
        pend <= 1'b1;
      end
      tc_r <= !tx_busy && !(te && (pend || pre || sbk)) && !data_wr;
    end
  end

  // receive flags
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf <= '0;
      {rdrf, ovr, nf, fe, idle_f, seen_char, st_armed} <= '0;
    end else begin
      if (rd && bus_addr == A_STAT) st_armed <= 1'b1;
      if (rd && bus_addr == A_DATA) st_armed <= 1'b0;
      if (clr) {rdrf, ovr, nf, fe, idle_f} <= '0;
      if (acc) begin
        if (rdrf && !clr) begin
          ovr <= 1'b1;
        end else begin
          rx_buf <= rx_data;
          rdrf <= 1'b1;
          nf <= rx_noise;
          fe <= rx_ferr;
        end
      end
      if (rx_idle) seen_char <= 1'b0;
      else if (acc && !rx_ferr) seen_char <= 1'b1;
      if (rx_idle && seen_char && re && !rwu) idle_f <= 1'b1;
    end
  end

  assign stat_w = DW'({fe, nf, ovr, idle_f, rdrf, tc_r, !pend});
  assign ctrl_w = DW'({nine, sbk, rwu, ilie, rie, tcie, tie, re, te});

  always_comb begin
    case (bus_addr)
      A_DATA:  rd_mux = DW'(rx_buf);
      A_STAT:  rd_mux = stat_w;
      A_CTRL:  rd_mux = ctrl_w;
      default: rd_mux = DW'(div);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq <= 1'b0;
    end else begin
      if (rd) bus_rdata <= rd_mux;
      irq <= (tie && !pend) || (tcie && tc_r) || (rie && (rdrf || ovr)) || (ilie && idle_f);
    end
  end

  // R3: moving the character to the shifter empties the buffer
  a_r3_take_empties: assert property (@(posedge clk) disable iff (rst)
    (tx_take && !data_wr) |=> !pend);
  // R4: no completion while the shifter is busy
  a_r4_tc_waits: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> !tc_r);
  // R8: an overrun keeps the older character
  a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (rst)
    (acc && rdrf && !clr) |=> ($stable(rx_buf) && ovr));
  // R11: idle needs a good character since the last idle event
  a_r11_idle_needs_char: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_f) |-> $past(seen_char));
  // R13: no interrupt enables, no interrupt
  a_r13_irq_masked: assert property (@(posedge clk) disable iff (rst)
    !(tie || tcie || rie || ilie) |=> !irq);
endmodule

// File: tb/tb_async_serial_port.sv
module tb_async_serial_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, bus_en, bus_we, rxd;
  logic [1:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic txd, irq;

  async_serial_port dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd), .irq(irq));

  int nvec = 0;
  int nbad = 0;
  int bitclk = 32;
  bit m9 = 1'b0;
  bit finished = 1'b0;
  logic [9:0] expq[$];
  string reqq[$];

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic waitbits(input int n);
    repeat (n * bitclk) @(negedge clk);
  endtask

  task automatic wait_txd_low();
    @(negedge clk);
    while (txd) @(negedge clk);
  endtask

  task automatic expect_frame(input logic [8:0] d, input logic stopv, input string req);
    expq.push_back({stopv, d});
    reqq.push_back(req);
  endtask

  task automatic send_rx(input logic [8:0] d, input bit nine, input logic stopv, input int gbit);
    int nb;
    logic v;
    nb = nine ? 11 : 10;
    for (int k = 0; k < nb; k++) begin
      if (k == 0) v = 1'b0;
      else if (k == nb - 1) v = stopv;
      else v = d[k-1];
      for (int c = 0; c < bitclk; c++) begin
        @(negedge clk);
        rxd = (k == gbit && c >= bitclk / 2 && c < bitclk / 2 + bitclk / 16) ? ~v : v;
      end
    end
    @(negedge clk);
    rxd = 1'b1;
  endtask

  // monitor: decodes the serial output and compares against the queue
  initial begin : monitor
    logic [8:0] d;
    logic s;
    logic [9:0] e;
    string rq;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        repeat (bitclk / 2) @(negedge clk);
        if (txd === 1'b0) begin
          d = '0;
          for (int i = 0; i < (m9 ? 9 : 8); i++) begin
            repeat (bitclk) @(negedge clk);
            d[i] = txd;
          end
          repeat (bitclk) @(negedge clk);
          s = txd;
          if (expq.size() == 0) begin
            nvec++; nbad++;
            $display("FAIL R2 unexpected frame actual=%h expected=none", {s, d});
          end else begin
            e = expq.pop_front();
            rq = reqq.pop_front();
            check({rq, " serial frame"}, {6'd0, s, d}, {6'd0, e});
          end
          if (!s) while (!txd) @(negedge clk);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nvec++; nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] s;
    rst = 1'b1; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(2'd1, s);
    check("R1 status after reset", s, 16'h0003);
    check("R1 txd idle", {15'd0, txd}, 16'd1);
    check("R1 irq low", {15'd0, irq}, 16'd0);

    wr(2'd2, 16'h0003);
    waitbits(12);

    // R2/R3/R4 back-to-back characters
    expect_frame(9'h0A5, 1'b1, "R2");
    wr(2'd0, 16'h00A5);
    wait_txd_low();
    expect_frame(9'h03C, 1'b1, "R3");
    wr(2'd0, 16'h003C);
    rd(2'd1, s);
    check("R3 empty clear while waiting", s & 16'h0003, 16'h0000);
    waitbits(9);
    wait_txd_low();
    repeat (4) @(negedge clk);
    rd(2'd1, s);
    check("R4 empty set, complete low", s & 16'h0003, 16'h0001);
    waitbits(12);
    rd(2'd1, s);
    check("R4 complete after stop", s & 16'h0003, 16'h0003);

    // R2 nine-bit character
    wr(2'd2, 16'h0103);
    m9 = 1'b1;
    expect_frame(9'h1C3, 1'b1, "R2 nine-bit");
    wr(2'd0, 16'h01C3);
    waitbits(14);
    wr(2'd2, 16'h0003);
    m9 = 1'b0;

    // R5 disable mid character
    expect_frame(9'h096, 1'b1, "R5");
    wr(2'd0, 16'h0096);
    wait_txd_low();
    waitbits(3);
    wr(2'd2, 16'h0002);
    waitbits(10);
    check("R5 line high after finish", {15'd0, txd}, 16'd1);
    rd(2'd1, s);
    check("R4 complete when disabled", s & 16'h0003, 16'h0003);
    wr(2'd2, 16'h0003);
    waitbits(12);

    // R6 break
    wr(2'd2, 16'h0083);
    wait_txd_low();
    expect_frame(9'h000, 1'b0, "R6");
    wr(2'd2, 16'h0003);
    waitbits(12);
    check("R6 line high after break", {15'd0, txd}, 16'd1);
    rd(2'd1, s);
    check("R6 complete after break", s & 16'h0003, 16'h0003);

    // R11 no idle before any character
    rd(2'd1, s);
    check("R11 no idle before character", s & 16'h0008, 16'h0000);

    // R7 receive
    send_rx(9'h05A, 1'b0, 1'b1, -1);
    waitbits(1);
    rd(2'd1, s);
    check("R7 receive full only", s & 16'h007C, 16'h0004);
    rd(2'd0, s);
    check("R7 received data", s, 16'h005A);
    rd(2'd1, s);
    check("R12 receive full cleared", s & 16'h0004, 16'h0000);

    // R11/R12 idle
    waitbits(12);
    rd(2'd1, s);
    check("R11 idle after character", s & 16'h0008, 16'h0008);
    rd(2'd1, s);
    check("R12 status read alone keeps idle", s & 16'h0008, 16'h0008);
    rd(2'd0, s);
    rd(2'd1, s);
    check("R12 idle cleared", s & 16'h0008, 16'h0000);
    waitbits(12);
    rd(2'd1, s);
    check("R11 idle not repeated", s & 16'h0008, 16'h0000);

    // R13 interrupts
    wr(2'd2, 16'h0013);
    repeat (2) @(negedge clk);
    check("R13 irq low with flags clear", {15'd0, irq}, 16'd0);
    send_rx(9'h033, 1'b0, 1'b1, -1);
    waitbits(1);
    check("R13 irq on receive", {15'd0, irq}, 16'd1);
    rd(2'd1, s);
    rd(2'd0, s);
    check("R13 data", s, 16'h0033);
    repeat (2) @(negedge clk);
    check("R13 irq drops after clear", {15'd0, irq}, 16'd0);
    wr(2'd2, 16'h0007);
    repeat (2) @(negedge clk);
    check("R13 irq on transmit empty", {15'd0, irq}, 16'd1);
    wr(2'd2, 16'h0003);
    waitbits(12);
    rd(2'd1, s);
    rd(2'd0, s);

    // R8 overrun
    send_rx(9'h011, 1'b0, 1'b1, -1);
    send_rx(9'h022, 1'b0, 1'b1, -1);
    waitbits(1);
    rd(2'd1, s);
    check("R8 overrun and full", s & 16'h0034, 16'h0014);
    rd(2'd0, s);
    check("R8 older data kept", s, 16'h0011);
    waitbits(12);
    rd(2'd1, s);
    rd(2'd0, s);

    // R9 noise, slower divider
    wr(2'd3, 16'h0003);
    bitclk = 64;
    repeat (8) @(negedge clk);
    send_rx(9'h06C, 1'b0, 1'b1, 4);
    waitbits(1);
    rd(2'd1, s);
    check("R9 noise flag", s & 16'h0064, 16'h0024);
    rd(2'd0, s);
    check("R9 majority data", s, 16'h006C);
    waitbits(12);
    rd(2'd1, s);
    rd(2'd0, s);

    // R10 framing error
    send_rx(9'h047, 1'b0, 1'b0, -1);
    waitbits(2);
    rd(2'd1, s);
    check("R10 framing flag", s & 16'h0064, 16'h0044);
    rd(2'd0, s);
    check("R10 data", s, 16'h0047);
    waitbits(12);
    rd(2'd1, s);
    check("R11 no idle after framing error", s & 16'h0008, 16'h0000);

    // R14 receiver sleep
    wr(2'd2, 16'h0043);
    send_rx(9'h055, 1'b0, 1'b1, -1);
    waitbits(1);
    rd(2'd1, s);
    check("R14 character ignored", s & 16'h0004, 16'h0000);
    waitbits(12);
    rd(2'd2, s);
    check("R14 sleep cleared by idle", s & 16'h0040, 16'h0000);
    send_rx(9'h02B, 1'b0, 1'b1, -1);
    waitbits(1);
    rd(2'd1, s);
    check("R14 awake receive", s & 16'h0004, 16'h0004);
    rd(2'd0, s);
    check("R14 awake data", s, 16'h002B);

    waitbits(2);
    check("R2 all frames seen", 16'(expq.size()), 16'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule